// File: doc/BRIEF.md
# Host Halfword Port Bridge

This block connects a 16-bit host data port to a 32-bit internal word bus. The host reaches one of four registers through a 2-bit select and moves every 32-bit quantity as two halfwords. A halfword-identify input marks each access as the first or the second half. An order bit in the control register chooses whether the first halfword maps to the low or to the high 16 bits. When both halves of a data write have arrived, the block sends one 32-bit write to the internal bus, with the byte enables collected from the host. A read fetches a whole word, and the host then takes it out as two halfwords.

In the incrementing data mode, the address register steps by 4 after each completed word. After the second halfword of a read, the block fetches the next word in the background. The host sees this through a wait output that is high while any internal transfer is in flight. The host raises its strobe only while the wait output is low. Strobe rising edges are detected in the system clock domain.

The controller is a state machine with seven states:
- ST_IDLE: accepts host accesses. It leaves on:
  - the second-half data write, to ST_WR_REQ;
  - a first-half data read when no valid word is held, to ST_RD_REQ;
  - a second-half incrementing data read, to ST_PF_REQ.
- ST_WR_REQ, ST_RD_REQ and ST_PF_REQ: each issues a one-cycle request and moves to ST_WR_WAIT, ST_RD_WAIT or ST_PF_WAIT.
- ST_WR_WAIT, ST_RD_WAIT and ST_PF_WAIT: each returns to ST_IDLE on acknowledge.

Top module: `hhb_bridge`

## Requirements
- R1: After reset, h_wait, m_req and h_dout are 0, the order bit is 0 and the address register is 0.
- R2: The select input picks the register. 00 is control, 01 is address, 10 is data with increment and 11 is data without increment. Control bit 0 is the order bit. A first-half control write loads it from h_din[0], and a control read returns it in h_dout[0] with all other bits 0.
- R3: The address register is written and read as two halfwords. The first half (h_half=0) maps to bits 15:0 when order is 0 and to bits 31:16 when order is 1. The second half maps to the other 16 bits.
- R4: A second-half data write issues exactly one bus write with m_we=1. It goes to the address register, and m_wdata holds both halves placed by the R3 mapping.
- R5: The 2-bit byte-enable pair sent with each halfword goes to the m_be lanes of the 16 bits that halfword maps to. A halfword write that enables only the low 16 bits therefore gives m_be=0011.
- R6: A first-half write never raises h_wait. After a second-half data write, h_wait is high until the acknowledge has been taken.
- R7: After a write with select 10, the address register advances by 4. With select 11, it is unchanged.
- R8: A first-half data read with no valid word raises h_wait and issues a read at the address register. The host then gets the first half of the returned word.
- R9: A second-half data read returns the other half of the same word. With select 10 it also advances the address by 4 and prefetches from the new address, with h_wait high until that prefetch completes.
- R10: A first-half data read after a prefetch issues no bus request, does not raise h_wait, and returns the prefetched word.
- R11: A write to the address register discards the held word. The next first-half data read fetches from the new address.
- R12: m_req is high for one cycle per transfer, and each bus transfer carries exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_din | input | 16 | Host write halfword |
| h_dout | output | 16 | Host read halfword, valid once h_wait is low |
| h_be | input | 2 | Host byte enables for this halfword |
| h_rnw | input | 1 | 1 read, 0 write |
| h_sel | input | 2 | Register select |
| h_half | input | 1 | 0 first halfword, 1 second halfword |
| h_strobe | input | 1 | Access strobe, acts on rising edge |
| h_wait | output | 1 | High while an internal transfer is pending |
| m_req | output | 1 | One-cycle bus request |
| m_we | output | 1 | Write flag qualified by m_req |
| m_addr | output | 32 | Bus word address |
| m_wdata | output | 32 | Bus write data |
| m_be | output | 4 | Bus byte enables |
| m_rdata | input | 32 | Bus read data, taken with m_ack |
| m_ack | input | 1 | Transfer acknowledge |

## Verification
Data writes are driven with random halfwords, random byte-enable pairs and both order settings. This separates a correct lane mapping from a swapped one, and correct enables from enables that are forced on. Read pairs are mixed in both data modes at random addresses. The bench counts bus requests per access, which tells a fetch apart from a hit on the held word, and it checks the address used by each prefetch. Directed cases cover the following:
- a write that enables only the low half;
- a read after an address write that follows a prefetch;
- readback of the address register after each kind of write.

// File: rtl/hhb_pkg.sv
package hhb_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL     = 2'b00,
        SEL_ADDR     = 2'b01,
        SEL_DATA_INC = 2'b10,
        SEL_DATA     = 2'b11
    } hsel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_PF_REQ,
        ST_PF_WAIT
    } st_e;

endpackage

// File: rtl/hhb_strobe_det.sv
module hhb_strobe_det (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/hhb_fsm.sv
module hhb_fsm
    import hhb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rise,
    input  logic  rnw,
    input  logic  half,
    input  hsel_e sel,
    input  logic  dvalid,
    input  logic  ack,
    output logic  acc,
    output logic  busy,
    output logic  req,
    output logic  we,
    output logic  fetch_done,
    output logic  pf_done,
    output logic  wr_done
);
    st_e state_q, state_d;
    logic is_data;

    assign is_data = (sel == SEL_DATA_INC) || (sel == SEL_DATA);
    assign acc     = rise && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc && is_data) begin
                    if (!rnw && half)                           state_d = ST_WR_REQ;
                    else if (rnw && !half && !dvalid)           state_d = ST_RD_REQ;
                    else if (rnw && half && sel == SEL_DATA_INC) state_d = ST_PF_REQ;
                end
            end
            ST_WR_REQ:  state_d = ST_WR_WAIT;
            ST_WR_WAIT: if (ack) state_d = ST_IDLE;
            ST_RD_REQ:  state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (ack) state_d = ST_IDLE;
            ST_PF_REQ:  state_d = ST_PF_WAIT;
            ST_PF_WAIT: if (ack) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy       = (state_q != ST_IDLE);
        req        = (state_q == ST_WR_REQ) || (state_q == ST_RD_REQ) || (state_q == ST_PF_REQ);
        we         = (state_q == ST_WR_REQ);
        fetch_done = (state_q == ST_RD_WAIT) && ack;
        pf_done    = (state_q == ST_PF_WAIT) && ack;
        wr_done    = (state_q == ST_WR_WAIT) && ack;
    end

    // R12: request lasts a single cycle
    assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    // R4: second-half data write launches a bus write
    assert_write_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !rnw && half && is_data) |=> (req && we));
    // R6: first-half write keeps the host running
    assert_first_write_nowait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !rnw && !half) |=> !busy);
    // R8: miss on first-half read fetches
    assert_miss_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rnw && !half && is_data && !dvalid) |=> (req && !we));
    // R9: incrementing second-half read prefetches
    assert_prefetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rnw && half && sel == SEL_DATA_INC) |=> (req && !we));
    // R10: hit on held word needs no bus cycle
    assert_hit_nowait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rnw && !half && is_data && dvalid) |=> (!busy && !req));
endmodule

// File: rtl/hhb_regfile.sv
module hhb_regfile
    import hhb_pkg::*;
#(
    parameter  int HW   = 16,
    parameter  int STEP = 4,
    localparam int BW   = HW / 8,
    localparam int WW   = 2 * HW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          rnw,
    input  logic          half,
    input  hsel_e         sel,
    input  logic [HW-1:0] hdata,
    input  logic [BW-1:0] hbe,
    input  logic          fetch_done,
    input  logic          pf_done,
    input  logic          wr_done,
    input  logic [WW-1:0] rdata,
    output logic [WW-1:0] addr,
    output logic [WW-1:0] wdata,
    output logic [2*BW-1:0] wbe,
    output logic          dvalid,
    output logic [HW-1:0] hout
);
    logic            order_q, inc_q, dvalid_q, lane;
    logic [WW-1:0]   addr_q, data_q;
    logic [2*BW-1:0] be_q;
    logic [HW-1:0]   hout_q;
    logic            addr_load;

    function automatic logic [HW-1:0] pick(input logic [WW-1:0] w, input logic hi);
        return hi ? w[WW-1:HW] : w[HW-1:0];
    endfunction

    assign lane      = half ^ order_q;
    assign addr_load = acc && !rnw && (sel == SEL_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q  <= 1'b0;
            inc_q    <= 1'b0;
            dvalid_q <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
            be_q     <= '0;
            hout_q   <= '0;
        end else begin
            if (acc && !rnw) begin
                unique case (sel)
                    SEL_CTRL: if (!half) order_q <= hdata[0];
                    SEL_ADDR: begin
                        if (lane) addr_q[WW-1:HW] <= hdata;
                        else      addr_q[HW-1:0]  <= hdata;
                        dvalid_q <= 1'b0;
                    end
                    default: begin
                        if (lane) begin
                            data_q[WW-1:HW]   <= hdata;
                            be_q[2*BW-1:BW]   <= hbe;
                        end else begin
                            data_q[HW-1:0]    <= hdata;
                            be_q[BW-1:0]      <= hbe;
                        end
                        dvalid_q <= 1'b0;
                        if (half) inc_q <= (sel == SEL_DATA_INC);
                    end
                endcase
            end
            if (acc && rnw) begin
                unique case (sel)
                    SEL_CTRL: hout_q <= {{(HW-1){1'b0}}, order_q};
                    SEL_ADDR: hout_q <= pick(addr_q, lane);
                    default: begin
                        if (half) begin
                            hout_q <= pick(data_q, lane);
                            if (sel == SEL_DATA_INC) begin
                                addr_q   <= addr_q + WW'(STEP);
                                dvalid_q <= 1'b0;
                            end
                        end else if (dvalid_q) begin
                            hout_q <= pick(data_q, lane);
                        end
                    end
                endcase
            end
            if (fetch_done) begin
                data_q   <= rdata;
                dvalid_q <= 1'b1;
                hout_q   <= pick(rdata, order_q);
            end
            if (pf_done) begin
                data_q   <= rdata;
                dvalid_q <= 1'b1;
            end
            if (wr_done && inc_q) addr_q <= addr_q + WW'(STEP);
        end
    end

    assign addr   = addr_q;
    assign wdata  = data_q;
    assign wbe    = be_q;
    assign dvalid = dvalid_q;
    assign hout   = hout_q;

    // R7: any address change other than a host load is one step forward
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_q != $past(addr_q)) && !$past(addr_load)) |-> (addr_q == $past(addr_q) + WW'(STEP)));
    // R11: a host address load leaves no held word
    assert_addr_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> !dvalid_q);
endmodule

// File: rtl/hhb_bridge.sv
module hhb_bridge
    import hhb_pkg::*;
#(
    parameter  int HW   = 16,
    parameter  int STEP = 4,
    localparam int BW   = HW / 8,
    localparam int WW   = 2 * HW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HW-1:0]   h_din,
    output logic [HW-1:0]   h_dout,
    input  logic [BW-1:0]   h_be,
    input  logic            h_rnw,
    input  logic [1:0]      h_sel,
    input  logic            h_half,
    input  logic            h_strobe,
    output logic            h_wait,
    output logic            m_req,
    output logic            m_we,
    output logic [WW-1:0]   m_addr,
    output logic [WW-1:0]   m_wdata,
    output logic [2*BW-1:0] m_be,
    input  logic [WW-1:0]   m_rdata,
    input  logic            m_ack
);
    hsel_e sel;
    logic  rise, acc, dvalid, fetch_done, pf_done, wr_done;

    assign sel = hsel_e'(h_sel);

    hhb_strobe_det u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (h_strobe),
        .rise   (rise)
    );

    hhb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .rnw        (h_rnw),
        .half       (h_half),
        .sel        (sel),
        .dvalid     (dvalid),
        .ack        (m_ack),
        .acc        (acc),
        .busy       (h_wait),
        .req        (m_req),
        .we         (m_we),
        .fetch_done (fetch_done),
        .pf_done    (pf_done),
        .wr_done    (wr_done)
    );

    hhb_regfile #(.HW(HW), .STEP(STEP)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .rnw        (h_rnw),
        .half       (h_half),
        .sel        (sel),
        .hdata      (h_din),
        .hbe        (h_be),
        .fetch_done (fetch_done),
        .pf_done    (pf_done),
        .wr_done    (wr_done),
        .rdata      (m_rdata),
        .addr       (m_addr),
        .wdata      (m_wdata),
        .wbe        (m_be),
        .dvalid     (dvalid),
        .hout       (h_dout)
    );
endmodule

// File: tb/hhb_bridge_tb_top.sv
module hhb_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] h_din = '0, h_dout;
    logic [1:0]  h_be = '0, h_sel = '0;
    logic        h_rnw = 1'b0, h_half = 1'b0, h_strobe = 1'b0, h_wait;
    logic        m_req, m_we, m_ack = 1'b0;
    logic [31:0] m_addr, m_wdata, m_rdata = '0;
    logic [3:0]  m_be;

    int checks = 0, errors = 0;

    // bus responder state
    logic [31:0] mem [16];
    int          req_cnt = 0;
    logic [31:0] lr_addr, lr_wdata;
    logic [3:0]  lr_be;
    logic        lr_we;
    logic        pend = 1'b0;
    int          lat = 0;

    // bench model
    logic        e_order = 1'b0;
    logic [31:0] e_addr = '0;
    logic        e_valid = 1'b0;
    logic        after_addr_wr = 1'b0;

    always #5 clk = ~clk;

    hhb_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .h_din(h_din), .h_dout(h_dout), .h_be(h_be),
        .h_rnw(h_rnw), .h_sel(h_sel), .h_half(h_half), .h_strobe(h_strobe),
        .h_wait(h_wait), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_be(m_be), .m_rdata(m_rdata), .m_ack(m_ack)
    );

    function automatic logic [15:0] pick(input logic [31:0] w, input logic hi);
        return hi ? w[31:16] : w[15:0];
    endfunction

    function automatic logic [31:0] place(input logic [15:0] d0, input logic [15:0] d1, input logic ord);
        return ord ? {d0, d1} : {d1, d0};
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'hA50F0000 ^ (i * 32'h01030507);
        forever begin
            @(negedge clk);
            m_ack = 1'b0;
            if (m_req) begin
                req_cnt++;
                lr_addr = m_addr; lr_wdata = m_wdata; lr_be = m_be; lr_we = m_we;
                pend = 1'b1;
                lat = $urandom_range(1, 3);
            end else if (pend) begin
                lat--;
                if (lat == 0) begin
                    pend = 1'b0;
                    m_ack = 1'b1;
                    m_rdata = mem[lr_addr[5:2]];
                    if (lr_we)
                        for (int b = 0; b < 4; b++)
                            if (lr_be[b]) mem[lr_addr[5:2]][8*b +: 8] = lr_wdata[8*b +: 8];
                end
            end
        end
    end

    task automatic host_acc(input logic rnw, input logic [1:0] sel, input logic half,
                            input logic [15:0] d, input logic [1:0] be,
                            output logic waited, output int nreq);
        int r0;
        @(negedge clk);
        while (h_wait) @(negedge clk);
        r0 = req_cnt;
        h_rnw = rnw; h_sel = sel; h_half = half; h_din = d; h_be = be; h_strobe = 1'b1;
        @(negedge clk);
        h_strobe = 1'b0;
        waited = h_wait;
        while (h_wait) @(negedge clk);
        nreq = req_cnt - r0;
    endtask

    task automatic set_order(input logic o);
        logic w; int n;
        host_acc(1'b0, 2'b00, 1'b0, {15'd0, o}, 2'b00, w, n);
        e_order = o;
    endtask

    task automatic write_addr(input logic [31:0] a);
        logic w; int n;
        host_acc(1'b0, 2'b01, 1'b0, pick(a, e_order), 2'b00, w, n);
        host_acc(1'b0, 2'b01, 1'b1, pick(a, ~e_order), 2'b00, w, n);
        e_addr = a; e_valid = 1'b0; after_addr_wr = 1'b1;
    endtask

    task automatic check_addr(input string rq);
        logic w; int n;
        host_acc(1'b1, 2'b01, 1'b0, 16'h0, 2'b00, w, n);
        check(rq, {16'd0, h_dout}, {16'd0, pick(e_addr, e_order)});
        host_acc(1'b1, 2'b01, 1'b1, 16'h0, 2'b00, w, n);
        check(rq, {16'd0, h_dout}, {16'd0, pick(e_addr, ~e_order)});
    endtask

    task automatic write_pair(input logic [1:0] sel, input logic [15:0] d0, input logic [1:0] b0,
                              input logic [15:0] d1, input logic [1:0] b1);
        logic w; int n;
        host_acc(1'b0, sel, 1'b0, d0, b0, w, n);
        check("R6 first write wait", {31'd0, w}, 32'd0);
        check("R12 first write no req", n, 0);
        host_acc(1'b0, sel, 1'b1, d1, b1, w, n);
        check("R6 second write wait", {31'd0, w}, 32'd1);
        check("R12 one write req", n, 1);
        check("R4 write flag", {31'd0, lr_we}, 32'd1);
        check("R4 write addr", lr_addr, e_addr);
        check("R4 write data", lr_wdata, place(d0, d1, e_order));
        check("R5 write be", {28'd0, lr_be}, {28'd0, e_order ? {b0, b1} : {b1, b0}});
        if (sel == 2'b10) e_addr = e_addr + 4;
        e_valid = 1'b0; after_addr_wr = 1'b0;
    endtask

    task automatic read_pair(input logic [1:0] sel);
        logic w; int n;
        logic [31:0] word;
        host_acc(1'b1, sel, 1'b0, 16'h0, 2'b00, w, n);
        word = mem[e_addr[5:2]];
        if (e_valid) begin
            check("R10 hit no req", n, 0);
            check("R10 hit no wait", {31'd0, w}, 32'd0);
            check("R10 hit data", {16'd0, h_dout}, {16'd0, pick(word, e_order)});
        end else begin
            check(after_addr_wr ? "R11 fetch req" : "R8 fetch req", n, 1);
            check(after_addr_wr ? "R11 fetch addr" : "R8 fetch addr", lr_addr, e_addr);
            check("R8 fetch is read", {31'd0, lr_we}, 32'd0);
            check("R8 wait raised", {31'd0, w}, 32'd1);
            check("R8 first half", {16'd0, h_dout}, {16'd0, pick(word, e_order)});
        end
        e_valid = 1'b1; after_addr_wr = 1'b0;
        host_acc(1'b1, sel, 1'b1, 16'h0, 2'b00, w, n);
        check("R9 second half", {16'd0, h_dout}, {16'd0, pick(word, ~e_order)});
        if (sel == 2'b10) begin
            e_addr = e_addr + 4;
            check("R9 prefetch req", n, 1);
            check("R9 prefetch addr", lr_addr, e_addr);
            check("R9 prefetch wait", {31'd0, w}, 32'd1);
        end else begin
            check("R9 no prefetch", n, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic w; int n;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 wait", {31'd0, h_wait}, 32'd0);
        check("R1 req", {31'd0, m_req}, 32'd0);
        check("R1 dout", {16'd0, h_dout}, 32'd0);
        check_addr("R1 addr");
        host_acc(1'b1, 2'b00, 1'b0, 16'h0, 2'b00, w, n);
        check("R1 order", {16'd0, h_dout}, 32'd0);
        // R2 control register
        set_order(1'b1);
        host_acc(1'b1, 2'b00, 1'b0, 16'h0, 2'b00, w, n);
        check("R2 ctrl read", {16'd0, h_dout}, 32'd1);
        set_order(1'b0);
        // R3 address halves in both orders
        write_addr(32'h0000_0010);
        check_addr("R3 addr o0");
        set_order(1'b1);
        write_addr(32'h0000_0020);
        check_addr("R3 addr o1");
        set_order(1'b0);
        write_addr(32'h0000_0010);
        // R5 low-half-only write, R7 no step with select 11
        write_pair(2'b11, 16'h5566, 2'b11, 16'h0000, 2'b00);
        check_addr("R7 no step");
        set_order(1'b1);
        write_pair(2'b10, 16'h1111, 2'b01, 16'h2222, 2'b10);
        check_addr("R7 step");
        // R10 prefetch then hit, R11 cancel
        read_pair(2'b10);
        read_pair(2'b10);
        write_addr(32'h0000_0008);
        read_pair(2'b10);
        // random mix
        for (int it = 0; it < 60; it++) begin
            int op;
            op = $urandom_range(0, 5);
            if (op == 0) set_order($urandom_range(0, 1) == 1);
            else if (op == 1) write_addr({26'd0, 4'($urandom_range(0, 14)), 2'b00});
            else if (op == 2) write_pair($urandom_range(0, 1) ? 2'b10 : 2'b11,
                                         16'($urandom), 2'($urandom), 16'($urandom), 2'($urandom));
            else if (op == 3) check_addr("R7 addr track");
            else read_pair($urandom_range(0, 1) ? 2'b10 : 2'b11);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule